// File: doc/BRIEF.md
# Start-Gated Pulse Decimator

This block divides down an external pulse train by a programmable ratio, but only once it has been armed. A one-cycle start strobe moves it from idle into a counting state and captures the 16-bit ratio. The external pulse is never used as a clock. It is brought into the system clock domain through a synchronizer chain, and each of its rising edges counts once. When the programmed number of pulses has been seen, the block raises a registered done strobe for one cycle and falls back to idle until the next start.

A typical use is an input pulse of roughly 50 to 100 ns that repeats at 100 kHz, sampled by a 40 MHz system clock. The done strobe then marks every Nth pulse after an arm command, and can start a later stage. A ratio of zero is treated as a ratio of one.

Top module: `pulse_decimator`

## Requirements
- R1: While rst is high at a clock edge, the block returns to idle with done low at that edge, even in the middle of a count. Pulses counted before the reset do not carry over.
- R2: In idle, input pulses have no effect, and done stays low. Only start=1 sampled at a clock edge leaves idle.
- R3: pulse_in passes through a two-stage synchronizer. When a pulse completes the count, done is high in the cycle after the third rising clock edge that follows the rising edge of pulse_in.
- R4: Each external pulse advances the count exactly once, whether it stays high for 1 cycle or for many cycles (rising-edge detection).
- R5: After arming with ratio N, done pulses on the Nth counted pulse and not on any earlier one. The block then returns to idle, and further pulses produce no done.
- R6: A captured ratio of 0 behaves like 1: the first pulse after arming produces done.
- R7: start=1 while counting is ignored. The count in progress continues and is not restarted.
- R8: done is high for exactly one clock cycle per completion.
- R9: count_in (16 bits, unsigned) is captured at the arming edge. Changes to count_in while counting have no effect. Ratios well above 255 are supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Arm strobe; sampled only in idle |
| pulse_in | input | 1 | Raw external pulse, asynchronous to clk |
| count_in | input | 16 | Decimation ratio, captured on arming |
| done | output | 1 | One-cycle completion strobe, registered |

## Verification
The bench drives pulse trains of several shapes. Single-cycle pulses against multi-cycle pulses show that each pulse counts once. Ratios of 0, 1, 4 and 1000 separate an off-by-one error from correct terminal detection and show that the full counter width is used. Pulses sent before any start, an extra start in the middle of a count, a reset in the middle of a count, and a ratio changed after arming each show whether the arm gating and the ratio capture are working. Every pulse checks done at the exact cycle predicted by the synchronizer latency, and checks that done is low in every other cycle.

// File: rtl/pulse_decimator_pkg.sv
package pulse_decimator_pkg;
  typedef enum logic {
    DEC_IDLE  = 1'b0,
    DEC_COUNT = 1'b1
  } dec_state_t;
endpackage

// File: rtl/pulse_edge_sync.sv
module pulse_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  // synchronizer chain, raw_in lands in stage 0
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= raw_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= 1'b0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import pulse_decimator_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] ratio,
  output logic             fire,
  output dec_state_t       state_o,
  output logic [CNT_W-1:0] idx_o,
  output logic [CNT_W-1:0] target_o
);
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] ZERO = '0;

  dec_state_t       state_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] target_q;
  logic             fire_q;
  logic             last_hit;

  assign last_hit = (idx_q == (target_q - ONE));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= DEC_IDLE;
      idx_q    <= ZERO;
      target_q <= ONE;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      unique case (state_q)
        DEC_IDLE: begin
          if (arm) begin
            state_q  <= DEC_COUNT;
            idx_q    <= ZERO;
            target_q <= (ratio == ZERO) ? ONE : ratio;
          end
        end
        DEC_COUNT: begin
          if (tick) begin
            if (last_hit) begin
              fire_q  <= 1'b1;
              state_q <= DEC_IDLE;
              idx_q   <= ZERO;
            end else begin
              idx_q <= idx_q + ONE;
            end
          end
        end
        default: state_q <= DEC_IDLE;
      endcase
    end
  end

  assign fire     = fire_q;
  assign state_o  = state_q;
  assign idx_o    = idx_q;
  assign target_o = target_q;
endmodule

// File: rtl/pulse_decimator.sv
module pulse_decimator
  import pulse_decimator_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             pulse_in,
  input  logic [CNT_W-1:0] count_in,
  output logic             done
);
  logic             pulse_edge;
  dec_state_t       state;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] target;

  pulse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .raw_in (pulse_in),
    .rise   (pulse_edge)
  );

  decim_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .arm      (start),
    .tick     (pulse_edge),
    .ratio    (count_in),
    .fire     (done),
    .state_o  (state),
    .idx_o    (idx),
    .target_o (target)
  );
endmodule

// File: rtl/pulse_decimator_checker.sv
module pulse_decimator_checker
  import pulse_decimator_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             pulse_edge,
  input logic             done,
  input dec_state_t       state,
  input logic [CNT_W-1:0] idx,
  input logic [CNT_W-1:0] target
);
  logic seen_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    seen_q <= 1'b1;
    rst_q  <= rst;
  end

  // R1: after a reset edge the block is idle with done low
  always @(posedge clk) begin
    if (seen_q === 1'b1 && rst_q === 1'b1) begin
      p_reset_idle_r1: assert (state == DEC_IDLE && done == 1'b0);
    end
  end

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (state == DEC_IDLE && !start) |=> (state == DEC_IDLE));

  p_done_from_edge_r5: assert property (@(posedge clk) disable iff (rst)
    (state == DEC_COUNT && !pulse_edge) |=> !done);

  p_idx_below_target_r5: assert property (@(posedge clk) disable iff (rst)
    (state == DEC_COUNT) |-> (idx < target));

  p_nonzero_target_r6: assert property (@(posedge clk) disable iff (rst)
    (state == DEC_COUNT) |-> (target != '0));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (state == DEC_COUNT && start && !pulse_edge) |=> (state == DEC_COUNT && $stable(idx)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind pulse_decimator pulse_decimator_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .pulse_edge (pulse_edge),
  .done       (done),
  .state      (state),
  .idx        (idx),
  .target     (target)
);

// File: tb/pulse_decimator_test.sv
`timescale 1ns/1ps
module pulse_decimator_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             pulse_in = 1'b0;
  logic [CNT_W-1:0] count_in = '0;
  logic             done;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  pulse_decimator #(.CNT_W(CNT_W), .SYNC_STAGES(2)) uut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .pulse_in (pulse_in),
    .count_in (count_in),
    .done     (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one pulse of given width; done sampled at every negedge of the window,
  // expected high only after the third rising edge when want_done is set
  task automatic send_pulse(input int width, input int gap, input bit want_done, input string tag);
    int bad_at = 0;
    int act = 0;
    pulse_in = 1'b1;
    for (int i = 1; i <= width + gap; i++) begin
      @(negedge clk);
      if (done !== ((i == 3) && want_done) && bad_at == 0) begin
        bad_at = i;
        act = done;
      end
      if (i == width) pulse_in = 1'b0;
    end
    check(bad_at == 0, tag, act, (bad_at == 3) ? int'(want_done) : 0);
  endtask

  task automatic arm(input int ratio);
    @(negedge clk);
    count_in = CNT_W'(ratio);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(done === 1'b0, "R1 done low after reset", done, 0);
  endtask

  task automatic t_no_start();
    for (int k = 0; k < 5; k++) send_pulse(1, 3, 1'b0, "R2 pulse in idle ignored");
  endtask

  task automatic t_ratio4_narrow();
    arm(4);
    for (int k = 1; k <= 4; k++) send_pulse(1, 3, k == 4, "R5 R3 ratio 4 narrow pulses");
    send_pulse(1, 3, 1'b0, "R5 back to idle after done");
  endtask

  task automatic t_wide_pulses();
    arm(2);
    send_pulse(10, 3, 1'b0, "R4 wide pulse counts once");
    send_pulse(7, 3, 1'b1, "R4 second wide pulse completes");
  endtask

  task automatic t_ratio1_and_0();
    arm(1);
    send_pulse(1, 3, 1'b1, "R5 ratio 1 first pulse");
    arm(0);
    send_pulse(2, 3, 1'b1, "R6 ratio 0 acts as 1");
  endtask

  task automatic t_start_while_counting();
    arm(3);
    send_pulse(1, 3, 1'b0, "R7 pulse 1 of 3");
    send_pulse(1, 3, 1'b0, "R7 pulse 2 of 3");
    arm(3);
    send_pulse(1, 3, 1'b1, "R7 restart ignored, third completes");
  endtask

  task automatic t_reset_mid_count();
    arm(3);
    send_pulse(1, 3, 1'b0, "R1 pre-reset pulse 1");
    send_pulse(1, 3, 1'b0, "R1 pre-reset pulse 2");
    do_reset();
    check(done === 1'b0, "R1 done low after mid-count reset", done, 0);
    send_pulse(1, 3, 1'b0, "R1 R2 idle after reset");
    arm(3);
    send_pulse(1, 3, 1'b0, "R1 count restarted p1");
    send_pulse(1, 3, 1'b0, "R1 count restarted p2");
    send_pulse(1, 3, 1'b1, "R1 count restarted p3");
  endtask

  task automatic t_ratio_captured();
    arm(3);
    count_in = CNT_W'(1);
    send_pulse(1, 3, 1'b0, "R9 ratio change ignored p1");
    send_pulse(1, 3, 1'b0, "R9 ratio change ignored p2");
    send_pulse(1, 3, 1'b1, "R9 captured ratio completes");
  endtask

  task automatic t_large_ratio();
    int early = 0;
    arm(1000);
    for (int k = 1; k < 1000; k++) begin
      pulse_in = 1'b1;
      for (int i = 1; i <= 4; i++) begin
        @(negedge clk);
        if (done !== 1'b0) early++;
        if (i == 1) pulse_in = 1'b0;
      end
    end
    check(early == 0, "R9 no done before pulse 1000", early, 0);
    send_pulse(1, 3, 1'b1, "R9 done on pulse 1000");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_no_start();
    t_ratio4_narrow();
    t_wide_pulses();
    t_ratio1_and_0();
    t_start_while_counting();
    t_reset_mid_count();
    t_ratio_captured();
    t_large_ratio();
    // R8 is covered by every send_pulse window: done high only at one sample
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule